// File: doc/BRIEF.md
# Programmable Countdown Interrupt Source

This block is a single countdown timer whose expiry behaviour comes from a packed 32-bit control word, the local vector entry. Two registers sit on a small write/read bus: the entry, and the initial count. Writing a non-zero initial count loads the counter. From there it falls by one on every clock.

The clock edge on which the counter steps from 1 to 0 is the expiry. On that edge the block checks the entry's mask bit. When the mask is clear, the block raises a one-cycle interrupt request. The request carries the vector, the delivery mode and the trigger mode copied from the entry. The periodic flag sets what follows expiry: the timer either reloads from the initial count and runs again, or stops at zero.

The current count and a running flag are brought out as ports, so a neighbouring block can watch the timer without a wider register map.

Top module: `lvt_timer`

## Requirements
- R1: After a synchronous active-high reset, both registers read as zero, the count is zero, the timer is not running and no request is raised.
- R2: Entry layout. The fields are: vector in bits 7:0, delivery mode in bits 10:8, delivery status in bit 12, polarity in bit 13, remote-request flag in bit 14, trigger mode in bit 15, mask in bit 16, periodic flag in bit 17. Bit 11 and bits 31:18 always read back as zero.
- R3: Select 1 addresses the initial count. A write to it stores the value and loads the counter with that value on the same edge. The counter then drops by exactly one per clock while running.
- R4: A request pulse appears exactly N clock edges after the edge that wrote initial count N, on the edge where the count moves from 1 to 0.
- R5: While a request is high, its vector, mode and trigger outputs equal bits 7:0, 10:8 and 15 of the entry as it stood at the expiry edge.
- R6: An expiry with the mask bit (bit 16) set raises no request. In periodic mode it still reloads the counter.
- R7: With the periodic bit (bit 17) set, expiry reloads the counter from the initial count. Requests then repeat every N clocks.
- R8: With the periodic bit clear, the timer stops at zero after the first expiry and raises no further request.
- R9: Writing an initial count of zero leaves the timer stopped, and no expiry ever follows. This also holds when the write lands during a countdown.
- R10: Writing the initial count during a countdown restarts the countdown from the new value. This holds even on the edge that would have been an expiry, and that edge then raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 entry, 1 initial count |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 entry, 1 initial count |
| rd_data | output | 32 | Registered read data, one clock after rd_sel |
| cur_count | output | CNT_W | Present counter value |
| running | output | 1 | Countdown active |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |
| irq_mode | output | 3 | Delivery mode of the request |
| irq_level | output | 1 | Trigger mode of the request |

## Verification
The assertions take it for granted that the initial count stored in the register is the value the counter last loaded. Because of this, a periodic reload can never bring in a value the bus did not also write as a load. The assertions also expect reset to be held for at least one clock before any bus activity, so every past-value term refers to a reset state.

The stimulus keeps within these limits. All bus traffic goes through one write task, and reset is asserted for several clocks at the start. Random counts stay between 1 and 12, so each observation window spans several periods, and single-cycle periodic operation is included.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;

  typedef struct packed {
    logic [13:0] rsv_hi;
    logic        periodic;
    logic        masked;
    logic        trig_level;
    logic        remote_req;
    logic        pol_low;
    logic        busy;
    logic        rsv11;
    logic [2:0]  mode;
    logic [7:0]  vector;
  } lvt_entry_t;

  localparam logic [31:0] ENTRY_RW_MASK = 32'h0003_F7FF;
  localparam logic        SEL_ENTRY     = 1'b0;
  localparam logic        SEL_INIT      = 1'b1;

endpackage

// File: rtl/lvt_regs.sv
module lvt_regs
  import lvt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             rd_sel,
  output logic [31:0]      rd_data,
  output lvt_entry_t       entry_o,
  output logic [CNT_W-1:0] init_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);

  lvt_entry_t       entry_q;
  logic [CNT_W-1:0] init_q;

  assign load_o     = wr_en && (wr_sel == SEL_INIT);
  assign load_val_o = wr_data[CNT_W-1:0];
  assign entry_o    = entry_q;
  assign init_o     = init_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q <= '0;
      init_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_ENTRY) entry_q <= lvt_entry_t'(wr_data & ENTRY_RW_MASK);
      else                     init_q  <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     rd_data <= '0;
    else if (rd_sel == SEL_INIT) rd_data <= 32'(init_q);
    else                         rd_data <= entry_q;
  end

  // Reserved entry bits never appear on the read port
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_ENTRY) |=> (rd_data[31:18] == '0 && rd_data[11] == 1'b0));

endmodule

// File: rtl/lvt_counter.sv
module lvt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             running_q;

  assign expire_o  = running_q && (count_q == ONE) && !load;
  assign count_o   = count_q;
  assign running_o = running_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      running_q <= 1'b0;
    end else if (load) begin
      count_q   <= load_val;
      running_q <= (load_val != '0);
    end else if (expire_o) begin
      if (periodic) begin
        count_q   <= reload_val;
        running_q <= (reload_val != '0);
      end else begin
        count_q   <= '0;
        running_q <= 1'b0;
      end
    end else if (running_q) begin
      count_q <= count_q - ONE;
    end
  end

  assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    (running_q && !load && count_q > ONE) |=> (count_q == $past(count_q) - ONE));

  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (expire_o && periodic) |=> (count_q == $past(reload_val) && running_q));

  assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (expire_o && !periodic) |=> (!running_q && count_q == '0));

  assert_zero_load_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (load && load_val == '0) |=> !running_q);

endmodule

// File: rtl/lvt_irq_gen.sv
module lvt_irq_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       expire,
  input  logic       masked,
  input  logic [7:0] vector,
  input  logic [2:0] mode,
  input  logic       trig_level,
  output logic       irq_valid,
  output logic [7:0] irq_vector,
  output logic [2:0] irq_mode,
  output logic       irq_level
);

  logic fire;
  assign fire = expire && !masked;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_mode   <= '0;
      irq_level  <= 1'b0;
    end else begin
      irq_valid <= fire;
      if (fire) begin
        irq_vector <= vector;
        irq_mode   <= mode;
        irq_level  <= trig_level;
      end
    end
  end

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (expire && masked) |=> !irq_valid);

  assert_payload_R5: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_vector == $past(vector) && irq_mode == $past(mode)
                   && irq_level == $past(trig_level)));

endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
  import lvt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             rd_sel,
  output logic [31:0]      rd_data,
  output logic [CNT_W-1:0] cur_count,
  output logic             running,
  output logic             irq_valid,
  output logic [7:0]       irq_vector,
  output logic [2:0]       irq_mode,
  output logic             irq_level
);

  lvt_entry_t       entry;
  logic [CNT_W-1:0] init_val;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expire;

  lvt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .entry_o(entry), .init_o(init_val),
    .load_o(load), .load_val_o(load_val)
  );

  lvt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .reload_val(init_val), .periodic(entry.periodic),
    .count_o(cur_count), .running_o(running), .expire_o(expire)
  );

  lvt_irq_gen u_irq (
    .clk(clk), .rst(rst), .expire(expire), .masked(entry.masked),
    .vector(entry.vector), .mode(entry.mode), .trig_level(entry.trig_level),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_mode(irq_mode),
    .irq_level(irq_level)
  );

  // A request only follows an edge on which the timer was counting
  assert_irq_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> $past(running));

  assert_load_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> (running && cur_count == $past(load_val) && !irq_valid));

endmodule

// File: tb/lvt_timer_tb.sv
module lvt_timer_tb;

  localparam int CNT_W = 32;
  localparam logic [31:0] RW_MASK = 32'h0003_F7FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [CNT_W-1:0] cur_count;
  logic running, irq_valid, irq_level;
  logic [7:0] irq_vector;
  logic [2:0] irq_mode;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lvt_timer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .cur_count(cur_count), .running(running),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_mode(irq_mode),
    .irq_level(irq_level)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_pulse(int k, int n, bit per, bit msk);
    if (msk || n == 0 || k == 0) return 1'b0;
    return per ? (k % n == 0) : (k == n);
  endfunction

  function automatic int exp_count(int k, int n, bit per);
    if (n == 0) return 0;
    if (per) return n - (k % n);
    return (k < n) ? n - k : 0;
  endfunction

  task automatic bus_write(input logic sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic sel, output logic [31:0] data);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    data = rd_data;
  endtask

  // k counts edges since the write edge of initial count n
  task automatic observe(input int n, input logic [31:0] ent, input int len);
    for (int k = 0; k <= len; k++) begin
      bit ep;
      if (k > 0) @(negedge clk);
      ep = exp_pulse(k, n, ent[17], ent[16]);
      check(cur_count == CNT_W'(exp_count(k, n, ent[17])), "R3", "count",
            cur_count, exp_count(k, n, ent[17]));
      check(irq_valid == ep, ent[16] ? "R6" : (ent[17] ? "R7" : "R4"),
            "irq_valid", irq_valid, ep);
      if (irq_valid && ep)
        check(irq_vector == ent[7:0] && irq_mode == ent[10:8] && irq_level == ent[15],
              "R5", "payload", {irq_level, irq_mode, irq_vector},
              {ent[15], ent[10:8], ent[7:0]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv, ent;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(cur_count == 0 && !running && !irq_valid, "R1", "reset outputs",
          {running, irq_valid}, 0);
    bus_read(1'b0, rv); check(rv == 0, "R1", "entry after reset", rv, 0);
    bus_read(1'b1, rv); check(rv == 0, "R1", "init after reset", rv, 0);

    // R2 layout: reserved bits read zero
    bus_write(1'b0, 32'hFFFF_FFFF);
    bus_read(1'b0, rv); check(rv == 32'h0003_F7FF, "R2", "entry all ones", rv, 32'h0003_F7FF);

    // R8 one-shot, unmasked
    ent = 32'h0000_85A7;
    bus_write(1'b0, ent); bus_write(1'b1, 32'd5); observe(5, ent, 15);
    check(!running, "R8", "stopped", running, 0);

    // R6 masked periodic still reloads
    ent = 32'h0003_0321;
    bus_write(1'b0, ent); bus_write(1'b1, 32'd4); observe(4, ent, 13);

    // R7 periodic unmasked, including period 1
    ent = 32'h0002_0242;
    bus_write(1'b0, ent); bus_write(1'b1, 32'd3); observe(3, ent, 10);
    bus_write(1'b1, 32'd1); observe(1, ent, 5);

    // R9 zero count while running stops it
    bus_write(1'b1, 32'd0); observe(0, ent, 20);
    check(!running, "R9", "zero count idle", running, 0);

    // R10 restart mid-count
    bus_write(1'b1, 32'd10); observe(10, ent, 4);
    bus_write(1'b1, 32'd6); observe(6, ent, 13);
    // R10 restart on the would-be expiry edge
    bus_write(1'b1, 32'd5); observe(5, ent, 3);
    bus_write(1'b1, 32'd7);
    check(!irq_valid, "R10", "no irq on rewrite edge", irq_valid, 0);
    check(cur_count == 7, "R10", "count after rewrite", cur_count, 7);
    observe(7, ent, 15);

    // Random mix
    for (int i = 0; i < 25; i++) begin
      ent = $urandom;
      n = $urandom_range(1, 12);
      bus_write(1'b0, ent);
      bus_write(1'b1, 32'(n));
      observe(n, ent, 3 * n + 3);
      bus_read(1'b0, rv); check(rv == (ent & RW_MASK), "R2", "entry readback", rv, ent & RW_MASK);
      bus_read(1'b1, rv); check(rv == 32'(n), "R3", "init readback", rv, n);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule